// File: doc/BRIEF.md
# Pulse-Skipping PWM Voltage Regulator

This block drives the switch of a boost converter with a fixed-frequency gate signal and regulates the output by dropping whole pulses instead of trimming their width. A period counter sets the switching rate. On the last cycle of every period, the block compares the most recent sample from an external converter with a target level. If the sample is below the target, the next period gets the configured nominal pulse width. If the sample has reached the target or gone above it, the next period gets no pulse at all.

The same boundary cycle can also ask the external converter for a new sample. One conversion plus its acquisition window can take longer than one switching period, so requests can be thinned to one every `decim_i + 1` periods. In periods where no fresh sample has arrived, the previous on/off decision is kept. The period length, the pulse width and the target are plain register inputs. The block takes each of them only in a boundary cycle, so a period already in progress is never altered.

Top module: `pskip_pwm_reg`

## Requirements
- R1: A period lasts `period_i + 1` clock cycles. The period counter runs from 0 to the latched period value, and the boundary cycle is the one where the counter equals that value. The first boundary is the second cycle after reset is released.
- R2: If the sample captured before a boundary is strictly below `setpt_i`, the gate in the following period is high for exactly `duty_i` cycles, counted from counter value 0, provided `duty_i` is not greater than `period_i`.
- R3: If that sample is equal to or greater than `setpt_i`, the gate stays low for the whole of the following period.
- R4: A new pulse width takes effect only at a boundary. A change on `duty_i` in the middle of a period leaves that period untouched and first shows up in the period after the next boundary.
- R5: `adc_start_o` is high for exactly one cycle, the boundary cycle, at the first boundary and then at every `(decim_i + 1)`-th boundary after it. It is low in every other cycle.
- R6: If no result (a one-cycle `adc_done_i` strobe carrying `adc_data_i`) has arrived since the previous boundary, the previous skip/no-skip decision is kept for the next period.
- R7: While reset is asserted, `gate_o` and `adc_start_o` are low. After reset, the gate stays low until the period that follows the first boundary at which a sample has been compared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Period length minus one, in clock cycles |
| duty_i | input | CNT_W | Nominal pulse width, in clock cycles |
| setpt_i | input | SMP_W | Regulation target compared with the sample |
| decim_i | input | DEC_W | Number of boundaries skipped between conversion requests |
| adc_data_i | input | SMP_W | Conversion result |
| adc_done_i | input | 1 | One-cycle strobe qualifying `adc_data_i` |
| adc_start_o | output | 1 | One-cycle conversion request |
| gate_o | output | 1 | Gate drive for the power switch |

## Verification
The bench sweeps rising and falling sample ramps through the target. One of these ramps lands exactly on the target. A design that compared with strict greater-than would emit a pulse in that period where one should be skipped. With thinned conversion requests, a design that cleared or re-evaluated its decision without a fresh sample would switch pulses on or off in the held periods. A mid-period change of pulse width is also applied. A design that took the width directly, without latching it at the boundary, would show an odd-width pulse in the period where the change happens. The reset check catches a gate that fires before any sample has been compared, or a conversion request raised while reset is asserted.

// File: rtl/pskip_pkg.sv
package pskip_pkg;

  // Decision that is applied at a period boundary
  typedef struct packed {
    logic valid;  // at least one sample has been compared
    logic skip;   // suppress the coming pulse
  } dec_t;

  // Fold a fresh comparison into the held decision
  function automatic dec_t resolve_dec(input dec_t held, input logic fresh,
                                       input logic at_or_above);
    dec_t r;
    r = held;
    if (fresh) begin
      r.valid = 1'b1;
      r.skip  = at_or_above;
    end
    return r;
  endfunction

endpackage

// File: rtl/pskip_timebase.sv
module pskip_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic             pmatch_o
);

  logic             live_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;

  assign pmatch_o = live_q && (cnt_q == per_q);
  assign cnt_o    = cnt_q;
  assign per_o    = per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      cnt_q  <= '0;
      per_q  <= '0;
    end else begin
      live_q <= 1'b1;
      if (pmatch_o) begin
        cnt_q <= '0;
        per_q <= period_i;
      end else if (live_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R1
  wrap_after_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pmatch_o |=> (cnt_q == '0));

  // R1
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (cnt_q <= per_q));

endmodule

// File: rtl/pskip_conv_sched.sv
module pskip_conv_sched #(
  parameter int DEC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pmatch_i,
  input  logic [DEC_W-1:0] decim_i,
  output logic             start_o
);

  logic [DEC_W-1:0] left_q;

  assign start_o = pmatch_i && (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (pmatch_i) begin
      left_q <= (left_q == '0) ? decim_i : left_q - 1'b1;
    end
  end

  // R5
  no_start_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pmatch_i) |=> $stable(left_q));

endmodule

// File: rtl/pskip_decide.sv
module pskip_decide
  import pskip_pkg::*;
#(
  parameter int SMP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pmatch_i,
  input  logic [SMP_W-1:0] setpt_i,
  input  logic [SMP_W-1:0] adc_data_i,
  input  logic             adc_done_i,
  output dec_t             dec_o,
  output logic             fresh_o,
  output logic [SMP_W-1:0] smp_o
);

  logic [SMP_W-1:0] smp_q;
  logic             fresh_q;
  dec_t             dec_q;

  function automatic logic reached(input logic [SMP_W-1:0] s,
                                   input logic [SMP_W-1:0] t);
    return s >= t;
  endfunction

  assign dec_o   = resolve_dec(dec_q, fresh_q, reached(smp_q, setpt_i));
  assign fresh_o = fresh_q;
  assign smp_o   = smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q   <= '0;
      fresh_q <= 1'b0;
      dec_q   <= '0;
    end else begin
      if (adc_done_i) smp_q <= adc_data_i;
      if (adc_done_i)    fresh_q <= 1'b1;
      else if (pmatch_i) fresh_q <= 1'b0;
      if (pmatch_i) dec_q <= dec_o;
    end
  end

  // R6
  hold_without_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmatch_i && !fresh_q) |=> $stable(dec_q));

  // R7
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_q.valid |=> dec_q.valid);

endmodule

// File: rtl/pskip_gate.sv
module pskip_gate
  import pskip_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pmatch_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  dec_t             dec_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             gate_o
);

  logic [CNT_W-1:0] duty_q;

  function automatic logic level_at(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] d);
    return c < d;
  endfunction

  assign gate_o = level_at(cnt_i, duty_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
    end else if (pmatch_i) begin
      duty_q <= (dec_i.valid && !dec_i.skip) ? duty_i : '0;
    end
  end

  // R4
  duty_only_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pmatch_i) |=> $stable(duty_q));

  // R2
  gate_rises_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> (cnt_i == '0));

endmodule

// File: rtl/pskip_pwm_reg.sv
module pskip_pwm_reg
  import pskip_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SMP_W = 8,
  parameter int DEC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [SMP_W-1:0] setpt_i,
  input  logic [DEC_W-1:0] decim_i,
  input  logic [SMP_W-1:0] adc_data_i,
  input  logic             adc_done_i,
  output logic             adc_start_o,
  output logic             gate_o
);

  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] per_w;
  logic             pmatch_w;
  dec_t             dec_w;
  logic             fresh_w;
  logic [SMP_W-1:0] smp_w;

  pskip_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(period_i),
    .cnt_o   (cnt_w),
    .per_o   (per_w),
    .pmatch_o(pmatch_w)
  );

  pskip_conv_sched #(.DEC_W(DEC_W)) u_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pmatch_i(pmatch_w),
    .decim_i (decim_i),
    .start_o (adc_start_o)
  );

  pskip_decide #(.SMP_W(SMP_W)) u_decide (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pmatch_i  (pmatch_w),
    .setpt_i   (setpt_i),
    .adc_data_i(adc_data_i),
    .adc_done_i(adc_done_i),
    .dec_o     (dec_w),
    .fresh_o   (fresh_w),
    .smp_o     (smp_w)
  );

  pskip_gate #(.CNT_W(CNT_W)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pmatch_i(pmatch_w),
    .cnt_i   (cnt_w),
    .dec_i   (dec_w),
    .duty_i  (duty_i),
    .gate_o  (gate_o)
  );

  // R5
  start_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> (cnt_w == per_w));

  // R3
  skip_after_high_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmatch_w && fresh_w && (smp_w >= setpt_i)) |=> !gate_o);

  // R7
  quiet_in_reset_chk: assert property (@(posedge clk_i)
    (!rst_ni) |-> (!gate_o && !adc_start_o));

endmodule

// File: tb/pskip_pwm_reg_bench.sv
module pskip_pwm_reg_bench;
  localparam int CNT_W = 16;
  localparam int SMP_W = 8;
  localparam int DEC_W = 4;
  localparam int LAT   = 6;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] period_i = '0;
  logic [CNT_W-1:0] duty_i = '0;
  logic [SMP_W-1:0] setpt_i = '0;
  logic [DEC_W-1:0] decim_i = '0;
  logic [SMP_W-1:0] adc_data_i = '0;
  logic             adc_done_i = 1'b0;
  logic             adc_start_o;
  logic             gate_o;

  pskip_pwm_reg #(.CNT_W(CNT_W), .SMP_W(SMP_W), .DEC_W(DEC_W)) u_pskip_pwm_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period_i), .duty_i(duty_i),
    .setpt_i(setpt_i), .decim_i(decim_i), .adc_data_i(adc_data_i),
    .adc_done_i(adc_done_i), .adc_start_o(adc_start_o), .gate_o(gate_o)
  );

  always #4 clk_i = ~clk_i;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    mon_on = 0;
  int    idx = 0;
  int    per_m = 1;
  int    dec_m = 0;
  int    acc = 0;
  int    periods_done = 0;
  int    base_v = 0;
  int    step_v = 0;
  int    smp_idx = 0;
  bit    pend = 0;
  int    lat = 0;

  function automatic int sval(input int i);
    return (base_v + step_v * i) & 255;
  endfunction

  // Monitor: scoreboard for pulse widths and conversion requests
  always @(negedge clk_i) begin
    if (mon_on) begin
      idx++;
      if ((idx - 1) % (per_m + 1) == 0) begin
        int b;
        b = (idx - 1) / (per_m + 1);
        checks++;
        if (adc_start_o !== (((b % (dec_m + 1)) == 0) ? 1'b1 : 1'b0)) begin
          errors++;
          $display("FAIL %s start at boundary %0d: actual %b expected %b",
                   (dec_m == 0) ? "R1" : "R5", b, adc_start_o, (b % (dec_m + 1)) == 0);
        end
        if (b >= 1) begin
          acc += (gate_o === 1'b1) ? 1 : 0;
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R1 period %0d: actual width %0d expected none queued", b, acc);
          end else begin
            int    w;
            string t;
            w = exp_q.pop_front();
            t = tag_q.pop_front();
            if (acc != w) begin
              errors++;
              $display("FAIL %s period %0d: actual width %0d expected %0d", t, b, acc, w);
            end
          end
          periods_done++;
        end
        acc = 0;
      end else begin
        if (adc_start_o !== 1'b0) begin
          checks++;
          errors++;
          $display("FAIL R5 start off-boundary at cycle %0d: actual 1 expected 0", idx);
        end
        acc += (gate_o === 1'b1) ? 1 : 0;
      end
    end
  end

  // Model converter: answers each request after LAT cycles with a ramp value
  always @(negedge clk_i) begin
    adc_done_i = 1'b0;
    if (mon_on) begin
      if (adc_start_o === 1'b1) begin
        pend = 1;
        lat  = LAT;
      end else if (pend) begin
        lat--;
        if (lat == 0) begin
          adc_done_i = 1'b1;
          adc_data_i = SMP_W'(sval(smp_idx));
          smp_idx++;
          pend = 0;
        end
      end
    end
  end

  // Driver: push expected widths, then run the phase
  task automatic run_phase(input int p, input int d, input int duty1, input int duty2,
                           input int chg, input int setv, input int b0, input int st,
                           input int nper, input string tag);
    mon_on = 0;
    rst_ni = 1'b0;
    period_i = CNT_W'(p);
    duty_i   = CNT_W'(duty1);
    setpt_i  = SMP_W'(setv);
    decim_i  = DEC_W'(d);
    repeat (3) @(negedge clk_i);
    // R7: quiet outputs while reset is held
    checks++;
    if (gate_o !== 1'b0 || adc_start_o !== 1'b0) begin
      errors++;
      $display("FAIL R7 reset outputs: actual gate %b start %b expected 0 0",
               gate_o, adc_start_o);
    end
    per_m = p; dec_m = d; base_v = b0; step_v = st;
    smp_idx = 0; pend = 0; acc = 0; periods_done = 0;
    exp_q.delete(); tag_q.delete();
    for (int k = 1; k <= nper; k++) begin
      int b;
      int w;
      int du;
      b  = k - 1;
      du = (chg > 0 && k >= chg + 1) ? duty2 : duty1;
      if (b < 1) w = 0;
      else w = (sval((b - 1) / (d + 1)) < setv) ? du : 0;
      exp_q.push_back(w);
      tag_q.push_back((k <= 2) ? "R7" : tag);
    end
    @(negedge clk_i);
    #1;
    idx = 0;
    mon_on = 1;
    rst_ni = 1'b1;
    if (chg > 0) begin
      while (idx < 1 + (chg - 1) * (p + 1) + p / 2) @(negedge clk_i);
      #1 duty_i = CNT_W'(duty2);  // R4: mid-period change
    end
    while (periods_done < nper) @(negedge clk_i);
    mon_on = 0;
  endtask

  initial begin
    // R2: rising ramp, step 3, crosses target 100
    run_phase(19, 0, 8, 8, 0, 100, 90, 3, 25, "R2");
    // R3: falling ramp hits target 105 exactly
    run_phase(11, 0, 5, 5, 0, 105, 110, -1, 20, "R3");
    // R6: request every second period, decision held in between
    run_phase(24, 1, 10, 10, 0, 60, 40, 5, 24, "R6");
    // R4: width changed in the middle of period 6
    run_phase(15, 0, 5, 12, 6, 200, 0, 1, 14, "R4");
    // R6: request every third period, falling ramp
    run_phase(15, 2, 15, 15, 0, 128, 200, -20, 20, "R6");
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule